// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block sits between the data path of a small display controller and its pixel store. The store is 64 byte columns wide and 80 rows tall; every byte packs two 4-bit pixels. Each pixel byte that arrives drives one write on the framebuffer port. The address is the current column plus 64 times the current row. After the write, a column/row pointer moves on to the next place inside a rectangular window.

The command path loads the window limits. A column load and a row load each take two argument bytes, a first and a last. Each argument is reduced modulo the size of its axis. A load also puts the pointer for that axis on the new first position. One order input selects how the pointer moves. In row-major order the column advances first and the row advances when the column wraps. In column-major order the row advances first and the column advances when the row wraps. A redraw flag tells the scan-out side that the picture has changed. Any pixel write sets it, and a clear strobe from the scan-out side resets it.

The write port is combinational from the current pointer. The pointer, the window registers and the redraw flag are registered. The storage itself is outside this block.

Top module: `fbw_addr_gen`

## Requirements
- R1: After reset both pointers and both window firsts are 0, the column last is 63, the row last is 79, and redraw is 0. The first pixel byte after reset is therefore written to address 0.
- R2: In the same cycle as a pixel strobe, the block drives fb_we high, drives fb_wdata with the pixel byte, and drives fb_addr with column + 64*row. Without a strobe, fb_we is 0 and the pointer does not move.
- R3: In row-major order (vert_order=0), each write moves the column on by one. When the moved column would exceed the column last, the column returns to the column first and the row moves on by one.
- R4: In row-major order, when the row would exceed the row last, it returns to the row first.
- R5: In column-major order (vert_order=1), each write moves the row on by one. When the moved row would exceed the row last, the row returns to the row first and the column moves on by one. A column that would exceed the column last returns to the column first.
- R6: A column load (col_load=1) sets the column pointer and the column first to win_first mod 64, and sets the column last to win_last mod 64.
- R7: A row load (row_load=1) sets the row pointer and the row first to win_first mod 80, and sets the row last to win_last mod 80.
- R8: A write sets redraw one cycle later. redraw_clr clears it when no write happens in that cycle. When a write and a clear fall in the same cycle, the write wins.
- R9: A load in the same cycle as a write lets the write use the old pointer. After that cycle the pointer holds the loaded value.
- R10: When a window's first is above its last, a write at the first moves the pointer on once and then wraps it back to the first. In row-major order the row then also moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel byte strobe |
| px_data | input | 8 | Pixel byte (two 4-bit pixels) |
| vert_order | input | 1 | 0: column advances first; 1: row advances first |
| col_load | input | 1 | Load the column window from win_first/win_last |
| row_load | input | 1 | Load the row window from win_first/win_last |
| win_first | input | 8 | First-position argument of a window load |
| win_last | input | 8 | Last-position argument of a window load |
| redraw_clr | input | 1 | Clear request from the scan-out side |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 13 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| redraw | output | 1 | Picture-changed flag |

## Verification
The write-port outputs follow the strobe and the pointer within the same cycle. The bench drives inputs on the falling edge and checks fb_we, fb_addr and fb_wdata one nanosecond later, before the rising edge that consumes them. Pointer moves, window loads and the redraw flag take effect at that rising edge. They are observed through the address of the next write, or by reading redraw just after the edge. Each expected address sequence, including wraps, reversed windows and writes that coincide with a load, is worked out by hand from the requirements.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    localparam int FB_COLS = 64;
    localparam int FB_ROWS = 80;
    localparam int ARG_W   = 8;
    localparam int COL_W   = $clog2(FB_COLS);
    localparam int ROW_W   = $clog2(FB_ROWS);
    localparam int ADDR_W  = $clog2(FB_COLS * FB_ROWS);

    typedef logic [COL_W-1:0] col_t;
    typedef logic [ROW_W-1:0] row_t;

    typedef struct packed {
        col_t first;
        col_t last;
    } col_win_t;

    typedef struct packed {
        row_t first;
        row_t last;
    } row_win_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } fb_pos_t;

    typedef enum logic {
        ORDER_ROW_MAJOR = 1'b0,
        ORDER_COL_MAJOR = 1'b1
    } scan_order_t;

    function automatic logic [ADDR_W-1:0] pos_to_addr(input fb_pos_t p);
        int unsigned a;
        a = int'(p.col) + FB_COLS * int'(p.row);
        return ADDR_W'(a);
    endfunction

endpackage

// File: rtl/fbw_window.sv
module fbw_window #(
    parameter int MOD        = 64,
    parameter int RESET_LAST = MOD - 1,
    parameter int ARG_W      = 8,
    localparam int W         = $clog2(MOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ARG_W-1:0] arg_first,
    input  logic [ARG_W-1:0] arg_last,
    output logic [W-1:0]     first_q,
    output logic [W-1:0]     last_q,
    output logic [W-1:0]     load_val
);

    logic [W-1:0] last_val;

    always_comb begin
        load_val = W'(32'(arg_first) % MOD);
        last_val = W'(32'(arg_last) % MOD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            last_q  <= W'(RESET_LAST);
        end else if (load) begin
            first_q <= load_val;
            last_q  <= last_val;
        end
    end

    // R6 / R7: loaded last equals argument reduced by the axis size
    assert_window_load_R6_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (32'(last_q) == 32'($past(arg_last)) % MOD)
              && (32'(first_q) == 32'($past(arg_first)) % MOD));

    assert_window_range_R6_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(first_q) < MOD) && (32'(last_q) < MOD));

endmodule

// File: rtl/fbw_pointer.sv
module fbw_pointer
    import fbw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  scan_order_t order,
    input  col_win_t    col_win,
    input  row_win_t    row_win,
    input  logic        col_load,
    input  logic        row_load,
    input  col_t        col_load_val,
    input  row_t        row_load_val,
    output fb_pos_t     pos
);

    int unsigned c_cur, r_cur, c_nxt, r_nxt;
    logic        wrap;
    fb_pos_t     pos_step;

    always_comb begin
        c_cur = int'(pos.col);
        r_cur = int'(pos.row);
        c_nxt = c_cur;
        r_nxt = r_cur;
        wrap  = 1'b0;
        if (order == ORDER_ROW_MAJOR) begin
            c_nxt = c_cur + 1;
            wrap  = (c_nxt > int'(col_win.last));
            if (wrap) begin
                c_nxt = int'(col_win.first);
                r_nxt = r_cur + 1;
            end
            if (r_nxt > int'(row_win.last)) begin
                r_nxt = int'(row_win.first);
            end
        end else begin
            r_nxt = r_cur + 1;
            wrap  = (r_nxt > int'(row_win.last));
            if (wrap) begin
                r_nxt = int'(row_win.first);
                c_nxt = c_cur + 1;
            end
            if (c_nxt > int'(col_win.last)) begin
                c_nxt = int'(col_win.first);
            end
        end
        pos_step.col = col_t'(c_nxt);
        pos_step.row = row_t'(r_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            if (advance) begin
                pos <= pos_step;
            end
            if (col_load) begin
                pos.col <= col_load_val;
            end
            if (row_load) begin
                pos.row <= row_load_val;
            end
        end
    end

    assert_hstep_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && order == ORDER_ROW_MAJOR && !col_load && !row_load
         && pos.col < col_win.last && pos.row <= row_win.last)
        |=> (pos.col == col_t'($past(pos.col) + 1'b1)) && (pos.row == $past(pos.row)));

    assert_hwrap_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && order == ORDER_ROW_MAJOR && !col_load && !row_load
         && pos.col == col_win.last)
        |=> pos.col == $past(col_win.first));

    assert_vstep_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && order == ORDER_COL_MAJOR && !col_load && !row_load
         && pos.row < row_win.last && pos.col <= col_win.last)
        |=> (pos.row == row_t'($past(pos.row) + 1'b1)) && (pos.col == $past(pos.col)));

    assert_vwrap_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && order == ORDER_COL_MAJOR && !col_load && !row_load
         && pos.row == row_win.last)
        |=> pos.row == $past(row_win.first));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!advance && !col_load && !row_load) |=> $stable(pos));

endmodule

// File: rtl/fbw_redraw.sv
module fbw_redraw (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(flag));

endmodule

// File: rtl/fbw_addr_gen.sv
module fbw_addr_gen
    import fbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              px_valid,
    input  logic [ARG_W-1:0]  px_data,
    input  logic              vert_order,
    input  logic              col_load,
    input  logic              row_load,
    input  logic [ARG_W-1:0]  win_first,
    input  logic [ARG_W-1:0]  win_last,
    input  logic              redraw_clr,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [ARG_W-1:0]  fb_wdata,
    output logic              redraw
);

    col_win_t    col_win;
    row_win_t    row_win;
    col_t        col_ld_val;
    row_t        row_ld_val;
    fb_pos_t     pos;
    scan_order_t order;

    assign order = scan_order_t'(vert_order);

    fbw_window #(.MOD(FB_COLS), .RESET_LAST(FB_COLS - 1), .ARG_W(ARG_W)) i_col_win (
        .clk       (clk),
        .rst       (rst),
        .load      (col_load),
        .arg_first (win_first),
        .arg_last  (win_last),
        .first_q   (col_win.first),
        .last_q    (col_win.last),
        .load_val  (col_ld_val)
    );

    fbw_window #(.MOD(FB_ROWS), .RESET_LAST(FB_ROWS - 1), .ARG_W(ARG_W)) i_row_win (
        .clk       (clk),
        .rst       (rst),
        .load      (row_load),
        .arg_first (win_first),
        .arg_last  (win_last),
        .first_q   (row_win.first),
        .last_q    (row_win.last),
        .load_val  (row_ld_val)
    );

    fbw_pointer i_pointer (
        .clk          (clk),
        .rst          (rst),
        .advance      (px_valid),
        .order        (order),
        .col_win      (col_win),
        .row_win      (row_win),
        .col_load     (col_load),
        .row_load     (row_load),
        .col_load_val (col_ld_val),
        .row_load_val (row_ld_val),
        .pos          (pos)
    );

    fbw_redraw i_redraw (
        .clk  (clk),
        .rst  (rst),
        .set  (px_valid),
        .clr  (redraw_clr),
        .flag (redraw)
    );

    always_comb begin
        fb_we    = px_valid;
        fb_wdata = px_data;
        fb_addr  = pos_to_addr(pos);
    end

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (32'(fb_addr) < FB_COLS * FB_ROWS));

endmodule

// File: tb/test_fbw_addr_gen.sv
module test_fbw_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        px_valid, vert_order, col_load, row_load, redraw_clr;
    logic [7:0]  px_data, win_first, win_last;
    logic        fb_we, redraw;
    logic [12:0] fb_addr;
    logic [7:0]  fb_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fbw_addr_gen i_fbw_addr_gen (
        .clk(clk), .rst(rst), .px_valid(px_valid), .px_data(px_data),
        .vert_order(vert_order), .col_load(col_load), .row_load(row_load),
        .win_first(win_first), .win_last(win_last), .redraw_clr(redraw_clr),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .redraw(redraw)
    );

    function automatic int pa(input int r, input int c);
        return r * 64 + c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        px_valid = 0; px_data = 0; col_load = 0; row_load = 0;
        win_first = 0; win_last = 0; redraw_clr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // one clock of stimulus; write port checked before the consuming edge
    task automatic step(input bit v, input logic [7:0] d, input bit cl, input bit rl,
                        input logic [7:0] f, input logic [7:0] l, input bit clr,
                        input int exp_addr, input string tag);
        @(negedge clk);
        px_valid = v; px_data = d; col_load = cl; row_load = rl;
        win_first = f; win_last = l; redraw_clr = clr;
        #1;
        check(fb_we == v, {tag, " we"}, int'(fb_we), int'(v));
        if (v) begin
            check(int'(fb_addr) == exp_addr, {tag, " addr"}, int'(fb_addr), exp_addr);
            check(fb_wdata == d, {tag, " data"}, int'(fb_wdata), int'(d));
        end
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic wr(input int exp_addr, input string tag);
        step(1, 8'(exp_addr ^ 8'h5A), 0, 0, 0, 0, 0, exp_addr, tag);
    endtask

    task automatic t_reset();
        vert_order = 0;
        do_reset();
        #1;
        check(redraw == 0, "R1 redraw after reset", int'(redraw), 0);
        check(fb_we == 0, "R2 no strobe", int'(fb_we), 0);
        wr(0, "R1 first write");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        wr(1, "R2 pointer held while idle");
    endtask

    task automatic t_hdefault();
        vert_order = 0;
        do_reset();
        for (int i = 0; i < 64; i++) wr(i, "R3 row 0 sweep");
        wr(64, "R3 column wrap bumps row");
        wr(65, "R3 next column");
    endtask

    task automatic t_hwindow();
        vert_order = 0;
        do_reset();
        step(0, 0, 1, 0, 8'h45, 8'h47, 0, 0, "R6 col load 69/71");
        step(0, 0, 0, 1, 8'hA2, 8'h53, 0, 0, "R7 row load 162/83");
        wr(pa(2,5), "R6 R7 pointer at firsts");
        wr(pa(2,6), "R3");
        wr(pa(2,7), "R3");
        wr(pa(3,5), "R3 column wrap");
        wr(pa(3,6), "R3");
        wr(pa(3,7), "R3");
        wr(pa(2,5), "R4 row wrap");
    endtask

    task automatic t_vwindow();
        vert_order = 1;
        do_reset();
        step(0, 0, 1, 0, 8'd5, 8'd7, 0, 0, "R6 col load");
        step(0, 0, 0, 1, 8'd2, 8'd3, 0, 0, "R7 row load");
        wr(pa(2,5), "R5");
        wr(pa(3,5), "R5 row first");
        wr(pa(2,6), "R5 row wrap bumps column");
        wr(pa(3,6), "R5");
        wr(pa(2,7), "R5");
        wr(pa(3,7), "R5");
        wr(pa(2,5), "R5 column wrap");
        vert_order = 0;
    endtask

    task automatic t_edge_window();
        vert_order = 0;
        do_reset();
        step(0, 0, 0, 1, 8'hFF, 8'hFF, 0, 0, "R7 row load 255");
        step(0, 0, 1, 0, 8'd62, 8'd63, 0, 0, "R6 col load");
        wr(pa(15,62), "R7 255 mod 80");
        wr(pa(15,63), "R3");
        wr(pa(15,62), "R4 single-row window");
    endtask

    task automatic t_redraw();
        vert_order = 0;
        do_reset();
        wr(0, "R8 write");
        check(redraw == 1, "R8 set by write", int'(redraw), 1);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8 clear");
        check(redraw == 0, "R8 cleared", int'(redraw), 0);
        step(1, 8'hC3, 0, 0, 0, 0, 1, 1, "R8 write with clear");
        check(redraw == 1, "R8 write wins", int'(redraw), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
        check(redraw == 1, "R8 held", int'(redraw), 1);
    endtask

    task automatic t_load_collide();
        vert_order = 0;
        do_reset();
        step(1, 8'h11, 1, 0, 8'd10, 8'd20, 0, 0, "R9 write uses old pointer");
        wr(pa(0,10), "R9 loaded pointer");
        step(1, 8'h22, 0, 1, 8'd40, 8'd50, 0, pa(0,11), "R9 row load with write");
        wr(pa(40,12), "R9 row loaded column moved");
    endtask

    task automatic t_reversed();
        vert_order = 0;
        do_reset();
        step(0, 0, 1, 0, 8'd10, 8'd5, 0, 0, "R10 col load 10/5");
        wr(pa(0,10), "R10 at first");
        wr(pa(1,10), "R10 wraps and bumps row");
        wr(pa(2,10), "R10 again");
    endtask

    initial begin
        rst = 1;
        vert_order = 0;
        idle_inputs();
        t_reset();
        t_hdefault();
        t_hwindow();
        t_vwindow();
        t_edge_window();
        t_redraw();
        t_load_collide();
        t_reversed();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule